// File: doc/BRIEF.md
# Push/Pop Register-List Decoder

This block decodes the register-list field of compressed push and pop instructions. One 16-bit instruction goes in, together with a select for a 32-bit or 64-bit register width and a flag that says the reduced 16-register base is active. The block then produces four results:

- a 32-bit mask of the registers the instruction saves or restores;
- the total stack-pointer adjustment in bytes;
- the two architectural register indices used by the paired register-move forms;
- an illegal-instruction flag.

A memory sequencer downstream uses the mask and the adjustment to issue its loads and stores.

The inputs enter through a valid/ready handshake, and the results are registered once. A result stays on the outputs until the consumer takes it. While a result waits, the block accepts no new instruction unless the consumer takes the held result in that same cycle.

Top module: `pushpop_rlist_decoder`

## Requirements
- R1: The register-list code is instruction bits 7:4. A code below 4 sets the illegal flag.
- R2: When the reduced-base flag is high, a code above 6 also sets the illegal flag.
- R3: When the illegal flag is set, the mask and the adjustment outputs are zero.
- R4: Saved-register index n maps to a register number as follows: n=0 to x8, n=1 to x9, and n=2..11 to x(16+n).
  - A legal code sets mask bit 1.
  - A code k in 5..14 also sets the bits of saved registers 0..k-5.
  - Code 15 sets the bits of saved registers 0..11.
  - No other mask bit is set.
- R5: With 32-bit width, the base adjustment is 16 bytes for codes 4–7, 32 for codes 8–11, 48 for codes 12–14, and 64 for code 15.
- R6: With 64-bit width, the base adjustment is as follows:
  - 16 bytes for codes 4–5
  - 32 for codes 6–7
  - 48 for codes 8–9
  - 64 for codes 10–11
  - 80 for codes 12–13
  - 96 for code 14
  - 112 for code 15
- R7: The adjustment output is the base plus instruction bits 3:2 multiplied by 16.
- R8: The first move selector is taken from bits 9:7 and the second from bits 4:2. Each is mapped to a register number through the R4 index mapping.
- R9: An input accepted on a clock edge (in_valid and in_ready both high) appears with out_valid high after that edge.
- R10: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_insn | input | 16 | Compressed instruction |
| in_xlen64 | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| in_rve | input | 1 | Reduced 16-register base active |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 32 | Bit i set when register xi is in the list |
| out_stack_adj | output | 8 | Stack-pointer adjustment in bytes |
| out_sreg1 | output | 5 | Register number from bits 9:7 |
| out_sreg2 | output | 5 | Register number from bits 4:2 |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
The assertions check these properties on every cycle:

- the handshake: a result follows each accepted input, a stalled result stays stable, and input is refused during a stall;
- the shape of any result: no mask or adjustment when illegal, mask bit 1 set when legal, no mask bit outside the saved set, the adjustment a multiple of 16, and move registers inside the saved set;
- the reduced-base limit, checked against the inputs that were accepted.

The exact mask for each code, and the exact adjustment in each width with each immediate, can only be shown by the bench's sweep against its own tables.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int INSN_W     = 16;
    localparam int XREG_W     = 5;
    localparam int RLIST_W    = 4;
    localparam int SEL_W      = 3;
    localparam int NUM_SAVED  = 12;
    localparam int RA_IDX     = 1;
    localparam int MIN_LEGAL  = 4;
    localparam int MAX_RVE    = 6;
    localparam int FRAME_ALGN = 16;

    // Saved-register index to architectural register number.
    function automatic logic [XREG_W-1:0] saved_to_xreg(input int n);
        int r;
        r = (n < 2) ? 8 + n : 16 + n;
        return r[XREG_W-1:0];
    endfunction

    typedef enum logic { WIDTH32 = 1'b0, WIDTH64 = 1'b1 } xwidth_e;

endpackage

// File: rtl/pp_sreg_map.sv
module pp_sreg_map
    import pp_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    output logic [XREG_W-1:0] xreg
);
    logic [XREG_W-1:0] sel_ext;

    always_comb begin
        sel_ext = {{(XREG_W-SEL_W){1'b0}}, sel};
        if (sel < SEL_W'(2)) begin
            xreg = XREG_W'(8) + sel_ext;
        end else begin
            xreg = XREG_W'(16) + sel_ext;
        end
    end
endmodule

// File: rtl/pp_legal_chk.sv
module pp_legal_chk
    import pp_pkg::*;
(
    input  logic [RLIST_W-1:0] code,
    input  logic               rve,
    output logic               illegal
);
    always_comb begin
        illegal = (code < RLIST_W'(MIN_LEGAL)) ||
                  (rve && (code > RLIST_W'(MAX_RVE)));
    end
endmodule

// File: rtl/pp_mask_gen.sv
module pp_mask_gen
    import pp_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic [RLIST_W-1:0] code,
    output logic [MASK_W-1:0]  mask
);
    localparam int CNT_W = $clog2(NUM_SAVED + 1);

    logic [CNT_W-1:0]     saved_cnt;
    logic [NUM_SAVED-1:0] saved_on;

    // Number of saved registers named by the code.
    always_comb begin
        if (code == RLIST_W'(15)) begin
            saved_cnt = CNT_W'(NUM_SAVED);
        end else if (code >= RLIST_W'(5)) begin
            saved_cnt = CNT_W'(code) - CNT_W'(4);
        end else begin
            saved_cnt = '0;
        end
    end

    for (genvar n = 0; n < NUM_SAVED; n++) begin : g_saved
        assign saved_on[n] = (CNT_W'(n) < saved_cnt);
    end

    always_comb begin
        mask = '0;
        mask[RA_IDX] = (code >= RLIST_W'(MIN_LEGAL));
        for (int n = 0; n < NUM_SAVED; n++) begin
            mask[saved_to_xreg(n)] = saved_on[n];
        end
    end
endmodule

// File: rtl/pp_adj_calc.sv
module pp_adj_calc
    import pp_pkg::*;
#(
    parameter int ADJ_W = 8
) (
    input  logic [RLIST_W-1:0] code,
    input  logic               xlen64,
    input  logic [1:0]         spimm,
    output logic [ADJ_W-1:0]   adj
);
    localparam int ALGN_BITS = $clog2(FRAME_ALGN);

    logic [ADJ_W-1:0] nregs;
    logic [ADJ_W-1:0] bytes;
    logic [ADJ_W-1:0] base;

    always_comb begin
        // Return address plus saved registers.
        if (code == RLIST_W'(15)) begin
            nregs = ADJ_W'(NUM_SAVED + 1);
        end else if (code >= RLIST_W'(MIN_LEGAL)) begin
            nregs = ADJ_W'(code) - ADJ_W'(MIN_LEGAL - 1);
        end else begin
            nregs = '0;
        end
        bytes = xlen64 ? (nregs << 3) : (nregs << 2);
        base  = (bytes + ADJ_W'(FRAME_ALGN - 1)) &
                ~ADJ_W'(FRAME_ALGN - 1);
        adj   = base + (ADJ_W'(spimm) << ALGN_BITS);
    end
endmodule

// File: rtl/pushpop_rlist_decoder.sv
module pushpop_rlist_decoder
    import pp_pkg::*;
#(
    parameter int MASK_W = 32,
    parameter int ADJ_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [INSN_W-1:0]    in_insn,
    input  logic                 in_xlen64,
    input  logic                 in_rve,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [MASK_W-1:0]    out_mask,
    output logic [ADJ_W-1:0]     out_stack_adj,
    output logic [XREG_W-1:0]    out_sreg1,
    output logic [XREG_W-1:0]    out_sreg2,
    output logic                 out_illegal
);
    localparam int NUM_SEL = 2;

    typedef struct packed {
        logic              valid;
        logic [MASK_W-1:0] mask;
        logic [ADJ_W-1:0]  adj;
        logic [XREG_W-1:0] r1;
        logic [XREG_W-1:0] r2;
        logic              illegal;
    } res_t;

    res_t res_d, res_q;

    logic [RLIST_W-1:0] code;
    logic [1:0]         spimm;
    logic [SEL_W-1:0]   sel  [NUM_SEL];
    logic [XREG_W-1:0]  xreg [NUM_SEL];
    logic [MASK_W-1:0]  mask_raw;
    logic [ADJ_W-1:0]   adj_raw;
    logic               illegal;
    logic               accept;

    assign code   = in_insn[7:4];
    assign spimm  = in_insn[3:2];
    assign sel[0] = in_insn[9:7];
    assign sel[1] = in_insn[4:2];

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        pp_sreg_map u_map (
            .sel  (sel[i]),
            .xreg (xreg[i])
        );
    end

    pp_legal_chk u_legal (
        .code    (code),
        .rve     (in_rve),
        .illegal (illegal)
    );

    pp_mask_gen #(.MASK_W(MASK_W)) u_mask (
        .code (code),
        .mask (mask_raw)
    );

    pp_adj_calc #(.ADJ_W(ADJ_W)) u_adj (
        .code   (code),
        .xlen64 (in_xlen64),
        .spimm  (spimm),
        .adj    (adj_raw)
    );

    assign in_ready = !res_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        res_d = res_q;
        if (res_q.valid && out_ready) begin
            res_d.valid = 1'b0;
        end
        if (accept) begin
            res_d.valid   = 1'b1;
            res_d.illegal = illegal;
            res_d.mask    = illegal ? '0 : mask_raw;
            res_d.adj     = illegal ? '0 : adj_raw;
            res_d.r1      = xreg[0];
            res_d.r2      = xreg[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid     = res_q.valid;
    assign out_mask      = res_q.mask;
    assign out_stack_adj = res_q.adj;
    assign out_sreg1     = res_q.r1;
    assign out_sreg2     = res_q.r2;
    assign out_illegal   = res_q.illegal;
endmodule

// File: rtl/pp_rlist_checker.sv
module pp_rlist_checker
    import pp_pkg::*;
#(
    parameter int MASK_W = 32,
    parameter int ADJ_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [INSN_W-1:0] in_insn,
    input logic              in_rve,
    input logic              out_valid,
    input logic              out_ready,
    input logic [MASK_W-1:0] out_mask,
    input logic [ADJ_W-1:0]  out_stack_adj,
    input logic [XREG_W-1:0] out_sreg1,
    input logic [XREG_W-1:0] out_sreg2,
    input logic              out_illegal
);
    logic [MASK_W-1:0] allowed;

    always_comb begin
        allowed = '0;
        allowed[RA_IDX] = 1'b1;
        for (int n = 0; n < NUM_SAVED; n++) begin
            allowed[saved_to_xreg(n)] = 1'b1;
        end
    end

    assert_e_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_rve && (in_insn[7:4] > 4'd6)) |=> out_illegal);

    assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_mask == '0 && out_stack_adj == '0));

    assert_ra_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |-> out_mask[RA_IDX]);

    assert_mask_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~allowed) == '0));

    assert_adj_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_stack_adj[3:0] == 4'd0));

    assert_sreg_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (allowed[out_sreg1] && allowed[out_sreg2] &&
                       out_sreg1 != XREG_W'(RA_IDX) && out_sreg2 != XREG_W'(RA_IDX)));

    assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) &&
            $stable(out_stack_adj) && $stable(out_sreg1) &&
            $stable(out_sreg2) && $stable(out_illegal)));

    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind pushpop_rlist_decoder pp_rlist_checker #(
    .MASK_W (MASK_W),
    .ADJ_W  (ADJ_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_insn       (in_insn),
    .in_rve        (in_rve),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_mask      (out_mask),
    .out_stack_adj (out_stack_adj),
    .out_sreg1     (out_sreg1),
    .out_sreg2     (out_sreg2),
    .out_illegal   (out_illegal)
);

// File: tb/pushpop_rlist_decoder_tb.sv
module pushpop_rlist_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_insn = '0;
    logic        in_xlen64 = 1'b0;
    logic        in_rve = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_mask;
    logic [7:0]  out_stack_adj;
    logic [4:0]  out_sreg1;
    logic [4:0]  out_sreg2;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pushpop_rlist_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .in_xlen64(in_xlen64), .in_rve(in_rve),
        .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
        .out_stack_adj(out_stack_adj), .out_sreg1(out_sreg1),
        .out_sreg2(out_sreg2), .out_illegal(out_illegal)
    );

    function automatic logic [4:0] m_xreg(input int n);
        int r;
        r = (n < 2) ? 8 + n : 16 + n;
        return r[4:0];
    endfunction

    function automatic bit m_illegal(input int code, input bit rve);
        return (code < 4) || (rve && code > 6);
    endfunction

    function automatic logic [31:0] m_mask(input int code, input bit rve);
        logic [31:0] m;
        int last;
        m = '0;
        if (m_illegal(code, rve)) return m;
        m[1] = 1'b1;
        last = (code == 15) ? 11 : code - 5;
        for (int n = 0; n <= last; n++) m[m_xreg(n)] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] m_adj(input int code, input bit x64,
                                         input int imm, input bit rve);
        int b;
        if (m_illegal(code, rve)) return 8'd0;
        if (!x64) begin
            if (code <= 7) b = 16;
            else if (code <= 11) b = 32;
            else if (code <= 14) b = 48;
            else b = 64;
        end else begin
            case (code)
                4, 5:   b = 16;
                6, 7:   b = 32;
                8, 9:   b = 48;
                10, 11: b = 64;
                12, 13: b = 80;
                14:     b = 96;
                default: b = 112;
            endcase
        end
        b = b + imm * 16;
        return b[7:0];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input int code, input bit x64, input int imm,
                           input bit rve, input int stall);
        logic [15:0] w;
        logic [31:0] mask_e;
        logic [7:0]  adj_e;
        bit          ill_e;
        w = 16'($urandom);
        w[7:4] = code[3:0];
        w[3:2] = imm[1:0];
        mask_e = m_mask(code, rve);
        adj_e  = m_adj(code, x64, imm, rve);
        ill_e  = m_illegal(code, rve);
        @(negedge clk);
        in_valid = 1'b1; in_insn = w; in_xlen64 = x64; in_rve = rve;
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "out_valid after accept", {31'd0, out_valid}, 32'd1);
        if (code < 4) check("R1", "illegal low code", {31'd0, out_illegal}, 32'd1);
        else if (rve && code > 6) check("R2", "illegal reduced base", {31'd0, out_illegal}, 32'd1);
        else check("R1", "legal code", {31'd0, out_illegal}, 32'd0);
        if (ill_e) begin
            check("R3", "mask zero", out_mask, 32'd0);
            check("R3", "adj zero", {24'd0, out_stack_adj}, 32'd0);
        end else begin
            check("R4", "mask", out_mask, mask_e);
            if (imm == 0)
                check(x64 ? "R6" : "R5", "base adj", {24'd0, out_stack_adj}, {24'd0, adj_e});
            else
                check("R7", "adj with imm", {24'd0, out_stack_adj}, {24'd0, adj_e});
        end
        check("R8", "sreg1", {27'd0, out_sreg1}, {27'd0, m_xreg(int'(w[9:7]))});
        check("R8", "sreg2", {27'd0, out_sreg2}, {27'd0, m_xreg(int'(w[4:2]))});
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R10", "in_ready low in stall", {31'd0, in_ready}, 32'd0);
            check("R10", "held valid", {31'd0, out_valid}, 32'd1);
            check("R10", "held mask", out_mask, ill_e ? 32'd0 : mask_e);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R9", "valid drops after take", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check("R11", "reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R11", "reset in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "idle in_ready", {31'd0, in_ready}, 32'd1);
        // Directed corners
        run_one(15, 1'b1, 3, 1'b0, 2);
        run_one(15, 1'b0, 0, 1'b0, 0);
        run_one(3, 1'b0, 2, 1'b0, 1);
        run_one(7, 1'b0, 0, 1'b1, 0);
        run_one(6, 1'b1, 1, 1'b1, 0);
        // Full sweep
        for (int c = 0; c < 16; c++)
            for (int x = 0; x < 2; x++)
                for (int i = 0; i < 4; i++)
                    for (int r = 0; r < 2; r++)
                        run_one(c, x[0], i, r[0], int'($urandom_range(0, 2)));
        // Random extra
        for (int k = 0; k < 100; k++)
            run_one(int'($urandom_range(0, 15)), 1'($urandom), int'($urandom_range(0, 3)),
                    1'($urandom), int'($urandom_range(0, 3)));
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < WATCHDOG; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule